// File: doc/BRIEF.md
# Period Interrupt Generator

This block watches the transfer strobes of an audio capture channel and an audio playback channel and counts the frames each one moves. Each channel has a packed configuration word that holds a period length and an enable bit. Every time an enabled channel completes its programmed number of transfers, the block latches a pending flag for that channel. The two flags are combined through a mask into one level-sensitive interrupt line.

Software drives the block through a simple register port with two address spaces. The channel space holds the two configuration words, a read-only word that reports the playback fetch size, and a write-only soft-reset word. The interrupt space holds the mask and the pending-status word. Software reads the pending-status word, handles the channels it finds set, and writes the same value back to clear them. A period that completes in the same cycle as its clear keeps its flag, so no event is lost.

Top module: `period_irq_gen`

## Requirements
- R1: After reset the pending status, the mask and both configuration words read as zero, and `irq` is low.
- R2: The capture configuration word is at channel-space address 0x4C and the playback one at 0x54. The period length is held in bits [8 +: CNT_W] and the enable in bit 0. All other bits read as zero and are dropped on write.
- R3: Channel-space address 0x58 is read-only and returns the FETCH_BYTES parameter in bits 23:8 and zero elsewhere. Writes to it change nothing.
- R4: An enabled channel whose period is N > 0 sets its pending bit after every Nth transfer strobe (bit 0 capture, bit 1 playback). Strobes on a disabled channel are not counted.
- R5: A channel programmed with period 0 never sets its pending bit.
- R6: Writing a channel's configuration word, or writing a 1 to its bit (bit 0 capture, bit 1 playback) of the soft-reset word at channel-space 0x2C, restarts that channel's count from zero.
- R7: The pending-status word is read at interrupt-space address 0x0C. Writing it clears each bit written as 1 and leaves bits written as 0 unchanged.
- R8: When a period completes in the same cycle as a write that clears its pending bit, the bit stays set.
- R9: The mask is at interrupt-space address 0x08, bits 1:0, and reads back what was written. `irq` is high exactly when some pending bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_xfer | input | 1 | One-cycle strobe per capture transfer |
| tx_xfer | input | 1 | One-cycle strobe per playback transfer |
| bus_wr | input | 1 | Register write strobe |
| bus_irq_space | input | 1 | 1 selects the interrupt space, 0 the channel space |
| bus_addr | input | ADDR_W | Byte address within the selected space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq | output | 1 | Level interrupt, OR of pending bits under the mask |

## Verification
If a period counter drifts, the wrong count shows at the ports as a pending bit that rises one or more strobes early or late. That bit is visible on the status read in the cycle after the deciding strobe. A lost restart shows up the same way, after the first period that follows the configuration write or soft reset. A wrong status or mask flop shows in `irq` and in the status readback in the cycle after the event or write that exposes it. The clear-versus-event collision is checked in its exact cycle, because a missed period cannot be recovered later.

// File: rtl/pig_pkg.sv
package pig_pkg;
   // channel indices; also the bit positions in status, mask and soft reset
   localparam int CH_RX  = 0;
   localparam int CH_TX  = 1;
   localparam int NUM_CH = 2;

   // channel-space addresses
   localparam logic [7:0] A_CFG_RX = 8'h4C;
   localparam logic [7:0] A_CFG_TX = 8'h54;
   localparam logic [7:0] A_FETCH  = 8'h58;
   localparam logic [7:0] A_SRST   = 8'h2C;
   // interrupt-space addresses
   localparam logic [7:0] A_MASK   = 8'h08;
   localparam logic [7:0] A_STAT   = 8'h0C;

   // field positions inside a configuration word
   localparam int CFG_EN_BIT  = 0;
   localparam int CFG_CNT_LSB = 8;
   localparam int FETCH_LSB   = 8;
   localparam int FETCH_W     = 16;
   localparam int BUS_W       = 32;

   function automatic logic [7:0] cfg_addr(input int ch);
      return (ch == CH_RX) ? A_CFG_RX : A_CFG_TX;
   endfunction
endpackage

// File: rtl/pig_chan_ctr.sv
module pig_chan_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             enable,
   input  logic [CNT_W-1:0] period,
   input  logic             xfer,
   output logic             period_done
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             counting;

   // a restart in the same cycle as a strobe wins: the strobe is dropped
   assign counting    = enable && xfer && (period != '0) && !restart;
   assign cnt_inc     = cnt_q + CNT_W'(1);
   assign period_done = counting && (cnt_inc == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (counting) begin
         cnt_q <= period_done ? '0 : cnt_inc;
      end
   end
endmodule

// File: rtl/pig_status.sv
module pig_status #(
   parameter int NCH     = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set,
   input  logic [NCH-1:0] clr,
   input  logic [NCH-1:0] mask,
   output logic [NCH-1:0] status,
   output logic           irq
);
   logic [NCH-1:0] status_q;
   logic           irq_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else begin
         // new events take priority over a simultaneous clear
         status_q <= (status_q & ~clr) | set;
      end
   end

   assign status  = status_q;
   assign irq_raw = |(status_q & mask);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/pig_regfile.sv
module pig_regfile
   import pig_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int CNT_W       = 16,
   parameter int NCH         = 2,
   parameter int FETCH_BYTES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic                      sel_int,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [BUS_W-1:0]          wdata,
   output logic [BUS_W-1:0]          rdata,
   input  logic [NCH-1:0]            status,
   output logic [NCH-1:0]            cfg_en,
   output logic [NCH-1:0][CNT_W-1:0] cfg_period,
   output logic [NCH-1:0]            restart,
   output logic [NCH-1:0]            stat_clr,
   output logic [NCH-1:0]            mask
);
   localparam logic [FETCH_W-1:0] FETCH_VAL = FETCH_W'(FETCH_BYTES);

   logic            wr_chan;
   logic            wr_int;
   logic            srst_hit;
   logic [NCH-1:0]  cfg_hit;
   logic [NCH-1:0]  mask_q;

   assign wr_chan  = wr && !sel_int;
   assign wr_int   = wr && sel_int;
   assign srst_hit = wr_chan && (addr == ADDR_W'(A_SRST));
   assign stat_clr = (wr_int && (addr == ADDR_W'(A_STAT))) ? wdata[NCH-1:0] : '0;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_cfg
         logic             en_q;
         logic [CNT_W-1:0] per_q;

         assign cfg_hit[c] = wr_chan && (addr == ADDR_W'(cfg_addr(c)));
         assign restart[c] = cfg_hit[c] || (srst_hit && wdata[c]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q  <= 1'b0;
               per_q <= '0;
            end else if (cfg_hit[c]) begin
               en_q  <= wdata[CFG_EN_BIT];
               per_q <= wdata[CFG_CNT_LSB +: CNT_W];
            end
         end

         assign cfg_en[c]     = en_q;
         assign cfg_period[c] = per_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_int && (addr == ADDR_W'(A_MASK))) begin
         mask_q <= wdata[NCH-1:0];
      end
   end
   assign mask = mask_q;

   always_comb begin
      rdata = '0;
      if (sel_int) begin
         if (addr == ADDR_W'(A_MASK)) rdata[NCH-1:0] = mask_q;
         if (addr == ADDR_W'(A_STAT)) rdata[NCH-1:0] = status;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (addr == ADDR_W'(cfg_addr(c))) begin
               rdata[CFG_CNT_LSB +: CNT_W] = cfg_period[c];
               rdata[CFG_EN_BIT]           = cfg_en[c];
            end
         end
         if (addr == ADDR_W'(A_FETCH)) rdata[FETCH_LSB +: FETCH_W] = FETCH_VAL;
      end
   end
endmodule

// File: rtl/period_irq_gen.sv
module period_irq_gen
   import pig_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int CNT_W       = 16,
   parameter int FETCH_BYTES = 4,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_xfer,
   input  logic              tx_xfer,
   input  logic              bus_wr,
   input  logic              bus_irq_space,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   localparam int NCH = NUM_CH;

   generate
      if (CNT_W < 1 || CFG_CNT_LSB + CNT_W > BUS_W) begin : g_bad_cnt
         $error("period_irq_gen: CNT_W must be 1..24");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("period_irq_gen: ADDR_W must be at least 8");
      end
      if (FETCH_BYTES < 0 || FETCH_BYTES >= (1 << FETCH_W)) begin : g_bad_fetch
         $error("period_irq_gen: FETCH_BYTES must fit 16 bits");
      end
   endgenerate

   logic [NCH-1:0]            xfer;
   logic [NCH-1:0]            evt;
   logic [NCH-1:0]            cfg_en;
   logic [NCH-1:0][CNT_W-1:0] cfg_period;
   logic [NCH-1:0]            restart;
   logic [NCH-1:0]            stat_clr;
   logic [NCH-1:0]            mask;
   logic [NCH-1:0]            status;

   assign xfer[CH_RX] = rx_xfer;
   assign xfer[CH_TX] = tx_xfer;

   pig_regfile #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NCH(NCH), .FETCH_BYTES(FETCH_BYTES)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel_int(bus_irq_space),
      .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
      .status(status), .cfg_en(cfg_en), .cfg_period(cfg_period),
      .restart(restart), .stat_clr(stat_clr), .mask(mask)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         pig_chan_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .restart(restart[c]),
            .enable(cfg_en[c]), .period(cfg_period[c]),
            .xfer(xfer[c]), .period_done(evt[c])
         );
      end
   endgenerate

   pig_status #(.NCH(NCH), .IRQ_REG(IRQ_REG)) u_stat (
      .clk(clk), .rst_n(rst_n), .set(evt), .clr(stat_clr),
      .mask(mask), .status(status), .irq(irq)
   );
endmodule

// File: rtl/pig_chk.sv
module pig_chk #(
   parameter int CNT_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            evt,
   input logic [1:0]            status,
   input logic [1:0]            mask,
   input logic [1:0]            clr,
   input logic [1:0]            cfg_en,
   input logic [1:0][CNT_W-1:0] cfg_period,
   input logic                  irq
);
   // R4: a completed period is pending in the next cycle
   a_r4_rx_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt[0] |=> status[0]);
   a_r4_tx_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt[1] |=> status[1]);
   // R4: disabled channels never complete a period
   a_r4_rx_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en[0] |-> !evt[0]);
   a_r4_tx_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en[1] |-> !evt[1]);
   // R4: a pending bit only rises because of a completed period
   a_r4_rx_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> $past(evt[0]));
   // R5: period zero is silent
   a_r5_rx_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_period[0] == '0) |-> !evt[0]);
   a_r5_tx_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_period[1] == '0) |-> !evt[1]);
   // R7: a clear without a competing event drops the bit
   a_r7_rx_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[0] && !evt[0]) |=> !status[0]);
   a_r7_tx_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[1] && !evt[1]) |=> !status[1]);
   // R8: an event in the same cycle as a clear wins
   a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[0] && evt[0]) |=> status[0]);
   // R9: a mask held at zero keeps the line low
   a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 2'b00 && $past(mask) == 2'b00) |-> !irq);
endmodule

bind period_irq_gen pig_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt(evt), .status(status), .mask(mask),
   .clr(stat_clr), .cfg_en(cfg_en), .cfg_period(cfg_period), .irq(irq)
);

// File: tb/sim_period_irq_gen.sv
`timescale 1ns/1ps
module sim_period_irq_gen;
   localparam int FB = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_xfer = 1'b0, tx_xfer = 1'b0;
   logic        bus_wr = 1'b0, bus_irq_space = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   always #10 clk = ~clk;

   period_irq_gen #(.FETCH_BYTES(FB)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_xfer(rx_xfer), .tx_xfer(tx_xfer),
      .bus_wr(bus_wr), .bus_irq_space(bus_irq_space), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   typedef struct {
      logic [31:0] exp;
      bit          is_irq;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   // monitor: compares each pushed expectation in the cycle it was issued
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   task automatic wr(input bit sp, input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_irq_space = sp; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pulse(input bit r, input bit t, input int n);
      for (int i = 0; i < n; i++) begin
         rx_xfer = r; tx_xfer = t;
         @(negedge clk);
         rx_xfer = 1'b0; tx_xfer = 1'b0;
      end
   endtask

   task automatic exp_rd(input bit sp, input logic [7:0] a, input logic [31:0] e,
                         input string tag);
      item_t it;
      bus_wr = 1'b0; bus_irq_space = sp; bus_addr = a;
      it.exp = e; it.is_irq = 1'b0; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
   endtask

   task automatic exp_irq(input bit e, input string tag);
      item_t it;
      it.exp = {31'b0, e}; it.is_irq = 1'b1; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
   endtask

   localparam bit CS = 1'b0, IS = 1'b1;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      exp_rd(IS, 8'h0C, 32'h0, "R1 status");
      exp_rd(IS, 8'h08, 32'h0, "R1 mask");
      exp_rd(CS, 8'h4C, 32'h0, "R1 rx cfg");
      exp_rd(CS, 8'h54, 32'h0, "R1 tx cfg");
      exp_irq(1'b0, "R1 irq");

      // R2 configuration word layout
      wr(CS, 8'h4C, (32'd3 << 8) | 32'd1);
      exp_rd(CS, 8'h4C, 32'h0000_0301, "R2 rx cfg");
      wr(CS, 8'h54, 32'hFF00_0306);
      exp_rd(CS, 8'h54, 32'h0000_0300, "R2 tx cfg masked");

      // R3 read-only fetch size
      exp_rd(CS, 8'h58, FB << 8, "R3 fetch");
      wr(CS, 8'h58, 32'hFFFF_FFFF);
      exp_rd(CS, 8'h58, FB << 8, "R3 fetch after write");
      exp_rd(CS, 8'h4C, 32'h0000_0301, "R3 rx cfg untouched");

      // R4 periodic events on rx, period 3
      pulse(1, 0, 2);
      exp_rd(IS, 8'h0C, 32'h0, "R4 rx before period");
      pulse(1, 0, 1);
      exp_rd(IS, 8'h0C, 32'h1, "R4 rx first period");
      wr(IS, 8'h0C, 32'h1);
      pulse(1, 0, 3);
      exp_rd(IS, 8'h0C, 32'h1, "R4 rx second period");
      wr(IS, 8'h0C, 32'h1);
      // R4 disabled tx ignores strobes
      pulse(0, 1, 4);
      exp_rd(IS, 8'h0C, 32'h0, "R4 tx disabled");
      wr(CS, 8'h54, (32'd2 << 8) | 32'd1);
      pulse(0, 1, 2);
      exp_rd(IS, 8'h0C, 32'h2, "R4 tx period");
      wr(IS, 8'h0C, 32'h2);

      // R5 zero period
      wr(CS, 8'h4C, 32'h0000_0001);
      pulse(1, 0, 5);
      exp_rd(IS, 8'h0C, 32'h0, "R5 zero period");

      // R6 restart by soft reset
      wr(CS, 8'h4C, (32'd4 << 8) | 32'd1);
      pulse(1, 0, 3);
      wr(CS, 8'h2C, 32'h1);
      pulse(1, 0, 3);
      exp_rd(IS, 8'h0C, 32'h0, "R6 soft reset restarts");
      pulse(1, 0, 1);
      exp_rd(IS, 8'h0C, 32'h1, "R6 period after soft reset");
      wr(IS, 8'h0C, 32'h1);
      // R6 restart by configuration rewrite
      pulse(1, 0, 3);
      wr(CS, 8'h4C, (32'd4 << 8) | 32'd1);
      pulse(1, 0, 3);
      exp_rd(IS, 8'h0C, 32'h0, "R6 cfg write restarts");
      pulse(1, 0, 1);
      exp_rd(IS, 8'h0C, 32'h1, "R6 period after cfg write");
      wr(IS, 8'h0C, 32'h1);

      // R7 selective clear
      wr(CS, 8'h4C, 32'h0000_0101);
      wr(CS, 8'h54, 32'h0000_0101);
      pulse(1, 1, 1);
      exp_rd(IS, 8'h0C, 32'h3, "R7 both pending");
      wr(IS, 8'h0C, 32'h1);
      exp_rd(IS, 8'h0C, 32'h2, "R7 clear rx only");
      wr(IS, 8'h0C, 32'h0);
      exp_rd(IS, 8'h0C, 32'h2, "R7 zero write keeps");
      wr(IS, 8'h0C, 32'h2);
      exp_rd(IS, 8'h0C, 32'h0, "R7 clear tx");

      // R8 event and clear in the same cycle
      pulse(1, 0, 1);
      rx_xfer = 1'b1;
      wr(IS, 8'h0C, 32'h1);
      rx_xfer = 1'b0;
      exp_rd(IS, 8'h0C, 32'h1, "R8 event beats clear");
      wr(IS, 8'h0C, 32'h1);
      exp_rd(IS, 8'h0C, 32'h0, "R8 plain clear");

      // R9 mask and interrupt line
      wr(IS, 8'h08, 32'hFFFF_FFFF);
      exp_rd(IS, 8'h08, 32'h3, "R9 mask readback");
      exp_irq(1'b0, "R9 nothing pending");
      pulse(1, 0, 1);
      exp_irq(1'b1, "R9 rx pending unmasked");
      wr(IS, 8'h08, 32'h2);
      exp_irq(1'b0, "R9 rx masked");
      wr(IS, 8'h08, 32'h1);
      exp_irq(1'b1, "R9 rx unmasked again");
      wr(IS, 8'h08, 32'h0);
      exp_irq(1'b0, "R9 all masked");

      @(negedge clk);
      #3;
      done = 1'b1;
      summary();
      $finish;
   end
endmodule